// File: doc/BRIEF.md
# Two-Port Semaphore Flag Unit

This block holds a small set of hardware lock flags that two independent ports share for software resource locking, apart from any shared memory. Each port reaches the flags by pulling its semaphore select low while its memory chip enable stays high. A short address picks one flag. A write carries a single meaningful bit: 0 asks for the flag and 1 gives it up. A read shows, on every bit of the data bus, whether this port holds the flag.

Arbitration happens inside each flag, so at most one port ever owns a flag. A request for a flag that the other port holds is remembered. It is granted when the owner releases. When both ports ask for the same free flag in the same clock, the left port wins and the right port's request waits. All state changes on the rising clock edge. Read data is combinational from the registered state.

Top module: `sema_flag_unit`

## Requirements
- R1: After a synchronous active-low reset, every flag is free and a read of any flag from either port returns 9'h1FF.
- R2: The address (bits [2:0] with the default of eight flags) selects exactly one flag; a write to one flag leaves every other flag unchanged.
- R3: An access happens only when semaphore select is low and chip enable is high. With both low, or with select high, a write changes nothing and the read data is 9'h000.
- R4: A write takes its meaning from data bit 0 alone (0 = request, 1 = release); bits [8:1] have no effect.
- R5: A read (write-enable high, output-enable low, legal access) drives all nine data bits with the same value: 0 if this port holds the flag, 1 otherwise. With output-enable high the read data is 9'h000.
- R6: A request for a free flag is granted at the next clock edge, and the requester then reads 0.
- R7: While one port holds a flag, the other port reads 1 for it, and a request from that other port is kept pending.
- R8: When the owner writes 1, the flag passes to the other port if that port has a pending request or requests in the same cycle; otherwise the flag becomes free.
- R9: When both ports request the same free flag in the same cycle, the left port is granted and the right port's request becomes pending.
- R10: No flag is ever held by both ports at once; simultaneous reads of one flag never both return 0.
- R11: A port that writes 1 to a flag it does not hold cancels its own pending request for that flag and does not disturb the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce_n | input | 1 | Left memory chip enable, active low (must be high for flag access) |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_we_n | input | 1 | Left write enable, low = write, high = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left flag address |
| l_wdata | input | 9 | Left write data, bit 0 used |
| l_rdata | output | 9 | Left read data |
| r_ce_n | input | 1 | Right memory chip enable, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_we_n | input | 1 | Right write enable, low = write, high = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right flag address |
| r_wdata | input | 9 | Right write data, bit 0 used |
| r_rdata | output | 9 | Right read data |

## Verification
The flags are driven with single-port requests and releases, which show grants and free flags, and with a request from the non-owner followed by the owner's release, which shows that pending requests are kept and handed over. Two patterns exercise arbitration on the same flag: requests from both ports in the same cycle, which show left priority, and a release in the same cycle as the other port's request, which shows direct hand-off. Illegal enable combinations, writes whose upper data bits are set, a release written by a non-owner, and reads with output-enable high separate a real access from one that must be ignored. Reads of neighbouring flags show that addressing is isolated.

// File: rtl/sema_pkg.sv
// Shared types for the semaphore flag unit.
// Assumes two ports only: left and right.
package sema_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_t;
endpackage

// File: rtl/sema_port_decode.sv
// Decodes one port's control pins into per-flag request and release
// strobes plus a read enable. Assumes the pins are already synchronous
// to clk. Select low together with chip enable low is illegal and decodes
// to no operation.
module sema_port_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                 ce_n,
    input  logic                 sem_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wbit,
    output logic [NUM_FLAGS-1:0] req_vec,
    output logic [NUM_FLAGS-1:0] rel_vec,
    output logic                 rd_en
);
    logic access;
    logic wr_en;
    logic [NUM_FLAGS-1:0] hit;

    // Legal access only with select low and chip enable high.
    assign access = ce_n & ~sem_n;
    assign wr_en  = access & ~we_n;
    assign rd_en  = access & we_n & ~oe_n;

    // One-hot flag select and strobes, one slice per flag.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sel
        assign hit[i]     = (addr == ADDR_W'(i));
        assign req_vec[i] = wr_en & hit[i] & ~wbit;
        assign rel_vec[i] = wr_en & hit[i] & wbit;
    end
endmodule

// File: rtl/sema_flag_cell.sv
// One two-sided semaphore flag: an owner register plus a pending-request
// bit per port. Assumes each port gives at most one strobe per cycle.
// Left wins a simultaneous request for a free flag.
module sema_flag_cell
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic held_l,
    output logic held_r
);
    owner_t owner, owner_nxt;
    logic   pend_l, pend_r;
    logic   pend_l_nxt, pend_r_nxt;

    // Next-state arbitration for owner and pending requests.
    always_comb begin
        owner_nxt  = owner;
        pend_l_nxt = pend_l;
        pend_r_nxt = pend_r;
        case (owner)
            OWN_NONE: begin
                pend_l_nxt = 1'b0;
                pend_r_nxt = 1'b0;
                if (req_l) begin
                    owner_nxt  = OWN_LEFT;
                    pend_r_nxt = req_r;
                end else if (req_r) begin
                    owner_nxt  = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                pend_l_nxt = 1'b0;
                if (rel_l) begin
                    owner_nxt  = (pend_r | req_r) ? OWN_RIGHT : OWN_NONE;
                    pend_r_nxt = 1'b0;
                end else if (req_r) begin
                    pend_r_nxt = 1'b1;
                end else if (rel_r) begin
                    pend_r_nxt = 1'b0;
                end
            end
            OWN_RIGHT: begin
                pend_r_nxt = 1'b0;
                if (rel_r) begin
                    owner_nxt  = (pend_l | req_l) ? OWN_LEFT : OWN_NONE;
                    pend_l_nxt = 1'b0;
                end else if (req_l) begin
                    pend_l_nxt = 1'b1;
                end else if (rel_l) begin
                    pend_l_nxt = 1'b0;
                end
            end
            default: begin
                owner_nxt  = OWN_NONE;
                pend_l_nxt = 1'b0;
                pend_r_nxt = 1'b0;
            end
        endcase
    end

    // State register with synchronous reset to free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner  <= OWN_NONE;
            pend_l <= 1'b0;
            pend_r <= 1'b0;
        end else begin
            owner  <= owner_nxt;
            pend_l <= pend_l_nxt;
            pend_r <= pend_r_nxt;
        end
    end

    assign held_l = (owner == OWN_LEFT);
    assign held_r = (owner == OWN_RIGHT);
endmodule

// File: rtl/sema_read_mux.sv
// Selects one port's view of the addressed flag and replicates it over
// the data bus: 0 when this port holds it, 1 otherwise. Drives zero when
// the port is not reading.
module sema_read_mux #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 9
) (
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_FLAGS-1:0] held,
    output logic [DATA_W-1:0]    rdata
);
    logic mine;

    // Pick the ownership bit of the addressed flag.
    always_comb begin
        mine = 1'b0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            if (addr == ADDR_W'(i)) mine = held[i];
        end
    end

    // Replicate the view or idle at zero.
    assign rdata = rd_en ? {DATA_W{~mine}} : '0;
endmodule

// File: rtl/sema_flag_unit.sv
// Top of the two-port semaphore flag unit: two port decoders, one flag
// cell per flag, and a read mux per port. Assumes both ports run on clk.
module sema_flag_unit #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 9,
    localparam int ADDR_W   = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_sem_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_ce_n,
    input  logic              r_sem_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic [NUM_FLAGS-1:0] req_l, rel_l, req_r, rel_r;
    logic [NUM_FLAGS-1:0] held_l, held_r;
    logic                 rd_l, rd_r;
    logic                 unused_wdata_hi;

    // Upper write bits carry no meaning.
    assign unused_wdata_hi = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

    sema_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_l (
        .ce_n(l_ce_n), .sem_n(l_sem_n), .we_n(l_we_n), .oe_n(l_oe_n),
        .addr(l_addr), .wbit(l_wdata[0]),
        .req_vec(req_l), .rel_vec(rel_l), .rd_en(rd_l)
    );

    sema_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_r (
        .ce_n(r_ce_n), .sem_n(r_sem_n), .we_n(r_we_n), .oe_n(r_oe_n),
        .addr(r_addr), .wbit(r_wdata[0]),
        .req_vec(req_r), .rel_vec(rel_r), .rd_en(rd_r)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        sema_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .req_l(req_l[i]), .rel_l(rel_l[i]),
            .req_r(req_r[i]), .rel_r(rel_r[i]),
            .held_l(held_l[i]), .held_r(held_r[i])
        );
    end

    sema_read_mux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_l (
        .rd_en(rd_l), .addr(l_addr), .held(held_l), .rdata(l_rdata)
    );

    sema_read_mux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_r (
        .rd_en(rd_r), .addr(r_addr), .held(held_r), .rdata(r_rdata)
    );
endmodule

// File: rtl/sema_flag_checker.sv
// Property checker for sema_flag_unit, attached by bind. Observes ports
// and the per-flag ownership vectors.
module sema_flag_checker #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_ce_n,
    input logic                 l_sem_n,
    input logic                 l_we_n,
    input logic                 l_oe_n,
    input logic [ADDR_W-1:0]    l_addr,
    input logic                 l_wbit,
    input logic [DATA_W-1:0]    l_rdata,
    input logic                 r_ce_n,
    input logic                 r_sem_n,
    input logic                 r_we_n,
    input logic                 r_oe_n,
    input logic [ADDR_W-1:0]    r_addr,
    input logic                 r_wbit,
    input logic [DATA_W-1:0]    r_rdata,
    input logic [NUM_FLAGS-1:0] held_l,
    input logic [NUM_FLAGS-1:0] held_r
);
    // R1: leaving reset, nothing is held.
    assert_reset_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (held_l == '0 && held_r == '0));

    // R10: never both owners.
    assert_mutex_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (held_l & held_r) == '0);

    // R3: illegal enable pair gives no read data.
    assert_illegal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && !l_sem_n) |-> (l_rdata == '0));

    // R5: a right-port read shows its view on all bits.
    assert_read_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce_n && !r_sem_n && r_we_n && !r_oe_n) |-> (r_rdata == {DATA_W{~held_r[r_addr]}}));

    // R6: left request for a free flag is granted.
    assert_grant_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n && !l_sem_n && !l_we_n && !l_wbit && !held_l[l_addr] && !held_r[l_addr])
        |=> held_l[$past(l_addr)]);

    // R9: simultaneous requests on a free flag go left.
    assert_left_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n && !l_sem_n && !l_we_n && !l_wbit &&
         r_ce_n && !r_sem_n && !r_we_n && !r_wbit &&
         l_addr == r_addr && !held_l[l_addr] && !held_r[l_addr])
        |=> (held_l[$past(l_addr)] && !held_r[$past(r_addr)]));

    // R8: left release with a same-cycle right request hands over.
    assert_handoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n && !l_sem_n && !l_we_n && l_wbit && held_l[l_addr] &&
         r_ce_n && !r_sem_n && !r_we_n && !r_wbit && l_addr == r_addr)
        |=> held_r[$past(r_addr)]);

    // R5: left read idle at zero with output enable high.
    assert_oe_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        l_oe_n |-> (l_rdata == '0));
endmodule

bind sema_flag_unit sema_flag_checker #(
    .NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_sem_n(l_sem_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_wbit(l_wdata[0]), .l_rdata(l_rdata),
    .r_ce_n(r_ce_n), .r_sem_n(r_sem_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_wbit(r_wdata[0]), .r_rdata(r_rdata),
    .held_l(held_l), .held_r(held_r)
);

// File: tb/tb_sema_flag_unit.sv
// Directed bench for sema_flag_unit: one task per scenario.
module tb_sema_flag_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_ce_n = 1'b1, l_sem_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1;
    logic [2:0] l_addr = '0;
    logic [8:0] l_wdata = '0;
    logic [8:0] l_rdata;
    logic       r_ce_n = 1'b1, r_sem_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1;
    logic [2:0] r_addr = '0;
    logic [8:0] r_wdata = '0;
    logic [8:0] r_rdata;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [8:0] FREE = 9'h1FF;
    localparam logic [8:0] MINE = 9'h000;

    sema_flag_unit dut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_sem_n(l_sem_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_ce_n(r_ce_n), .r_sem_n(r_sem_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_ce_n = 1'b1; l_sem_n = 1'b1; l_we_n = 1'b1; l_oe_n = 1'b1;
        r_ce_n = 1'b1; r_sem_n = 1'b1; r_we_n = 1'b1; r_oe_n = 1'b1;
    endtask

    // Write on either or both ports; committed at the next rising edge.
    task automatic wr(input bit le, input logic [2:0] la, input logic [8:0] ld,
                      input bit re, input logic [2:0] ra, input logic [8:0] rd);
        @(negedge clk);
        idle();
        if (le) begin l_sem_n = 1'b0; l_we_n = 1'b0; l_addr = la; l_wdata = ld; end
        if (re) begin r_sem_n = 1'b0; r_we_n = 1'b0; r_addr = ra; r_wdata = rd; end
        @(negedge clk);
        idle();
    endtask

    // Read both ports at once, sampled mid-cycle.
    task automatic rd2(input logic [2:0] la, input logic [2:0] ra,
                       output logic [8:0] lv, output logic [8:0] rv);
        @(negedge clk);
        l_sem_n = 1'b0; l_oe_n = 1'b0; l_we_n = 1'b1; l_addr = la;
        r_sem_n = 1'b0; r_oe_n = 1'b0; r_we_n = 1'b1; r_addr = ra;
        #1;
        lv = l_rdata; rv = r_rdata;
        #1;
        idle();
    endtask

    task automatic t_reset();
        logic [8:0] lv, rv;
        for (int i = 0; i < 8; i++) begin
            rd2(3'(i), 3'(i), lv, rv);
            chk($sformatf("R1 left flag %0d after reset", i), lv, FREE);
            chk($sformatf("R1 right flag %0d after reset", i), rv, FREE);
        end
    endtask

    task automatic t_grant_pend_release();
        logic [8:0] lv, rv;
        wr(1, 3'd2, 9'h000, 0, 3'd0, 9'h0);
        rd2(3'd2, 3'd2, lv, rv);
        chk("R6 left granted free flag", lv, MINE);
        chk("R7 right sees held flag as 1", rv, FREE);
        rd2(3'd3, 3'd1, lv, rv);
        chk("R2 neighbour flag untouched (left)", lv, FREE);
        chk("R2 neighbour flag untouched (right)", rv, FREE);
        wr(0, 3'd0, 9'h0, 1, 3'd2, 9'h000);
        rd2(3'd2, 3'd2, lv, rv);
        chk("R7 right request pending, still reads 1", rv, FREE);
        chk("R10 owner unchanged while other waits", lv, MINE);
        wr(1, 3'd2, 9'h001, 0, 3'd0, 9'h0);
        rd2(3'd2, 3'd2, lv, rv);
        chk("R8 released left reads 1", lv, FREE);
        chk("R8 pending right now granted", rv, MINE);
        wr(0, 3'd0, 9'h0, 1, 3'd2, 9'h001);
        rd2(3'd2, 3'd2, lv, rv);
        chk("R8 release with no waiter frees (left)", lv, FREE);
        chk("R8 release with no waiter frees (right)", rv, FREE);
    endtask

    task automatic t_simultaneous();
        logic [8:0] lv, rv;
        wr(1, 3'd5, 9'h000, 1, 3'd5, 9'h000);
        rd2(3'd5, 3'd5, lv, rv);
        chk("R9 left wins tie", lv, MINE);
        chk("R9 right loses tie", rv, FREE);
        wr(1, 3'd5, 9'h001, 0, 3'd0, 9'h0);
        rd2(3'd5, 3'd5, lv, rv);
        chk("R9 losing right request was kept pending", rv, MINE);
        chk("R10 left no longer holds", lv, FREE);
        wr(0, 3'd0, 9'h0, 1, 3'd5, 9'h001);
        // same-cycle hand-off
        wr(1, 3'd0, 9'h000, 0, 3'd0, 9'h0);
        wr(1, 3'd0, 9'h001, 1, 3'd0, 9'h000);
        rd2(3'd0, 3'd0, lv, rv);
        chk("R8 same-cycle release/request hands over", rv, MINE);
        chk("R8 releaser reads 1 after hand-off", lv, FREE);
        wr(0, 3'd0, 9'h0, 1, 3'd0, 9'h001);
    endtask

    task automatic t_illegal();
        logic [8:0] lv, rv;
        @(negedge clk);
        l_ce_n = 1'b0; l_sem_n = 1'b0; l_we_n = 1'b0; l_addr = 3'd1; l_wdata = 9'h000;
        @(negedge clk);
        l_we_n = 1'b1; l_oe_n = 1'b0;
        #1;
        chk("R3 illegal enable pair reads zero", l_rdata, 9'h000);
        idle();
        @(negedge clk);
        l_sem_n = 1'b1; l_we_n = 1'b0; l_addr = 3'd1; l_wdata = 9'h000;
        @(negedge clk);
        idle();
        rd2(3'd1, 3'd1, lv, rv);
        chk("R3 illegal and unselected writes ignored (left)", lv, FREE);
        chk("R3 illegal and unselected writes ignored (right)", rv, FREE);
    endtask

    task automatic t_bit0_and_oe();
        logic [8:0] lv, rv;
        wr(1, 3'd6, 9'h1FE, 0, 3'd0, 9'h0);
        rd2(3'd6, 3'd6, lv, rv);
        chk("R4 upper bits ignored, bit0=0 requests", lv, MINE);
        @(negedge clk);
        l_sem_n = 1'b0; l_we_n = 1'b1; l_oe_n = 1'b1; l_addr = 3'd6;
        #1;
        chk("R5 output enable high gives zero", l_rdata, 9'h000);
        idle();
        wr(1, 3'd6, 9'h001, 0, 3'd0, 9'h0);
        rd2(3'd6, 3'd6, lv, rv);
        chk("R4 bit0=1 with upper bits clear releases", lv, FREE);
        chk("R5 right read replicated on all bits", rv, FREE);
    endtask

    task automatic t_cancel();
        logic [8:0] lv, rv;
        wr(1, 3'd7, 9'h000, 0, 3'd0, 9'h0);
        wr(0, 3'd0, 9'h0, 1, 3'd7, 9'h000);
        wr(0, 3'd0, 9'h0, 1, 3'd7, 9'h001);
        rd2(3'd7, 3'd7, lv, rv);
        chk("R11 non-owner release leaves owner", lv, MINE);
        wr(1, 3'd7, 9'h001, 0, 3'd0, 9'h0);
        rd2(3'd7, 3'd7, lv, rv);
        chk("R11 cancelled request not granted", rv, FREE);
        chk("R11 flag free after owner release", lv, FREE);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_grant_pend_release();
        t_simultaneous();
        t_illegal();
        t_bit0_and_oe();
        t_cancel();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule